// File: doc/BRIEF.md
# SPI Serial Memory Read Engine

This block is the target side of a serial flash memory for the two read commands: plain read and fast read. It uses a four-wire SPI link in mode 0. The serial clock idles low. The controller drives data-in before each rising clock edge, and the block changes data-out on each falling edge. After chip select falls, the block takes in an 8-bit opcode and then a 24-bit start address. A fast read also takes eight dummy bits. The block then streams bytes from an internal byte-wide array, one byte after another, for as long as chip select stays low.

The serial pins are sampled by a faster system clock and their edges are detected in that domain. The read address advances by one after each byte and wraps to zero past the top of the array. A busy flag from the program/erase engine next to it turns any read that arrives during such a cycle into a silent no-op. The data-out pin is modelled as a data bit plus an output enable. Enable low stands for high impedance.

Top module: `spi_read_engine`

## Requirements
- R1: After reset, the output enable is low. Whenever chip select has been high for at least three system clock cycles, the output enable is low.
- R2: Opcode bits are taken from data-in on rising serial clock edges, most significant bit first. Opcode 0x03 selects plain read. Opcode 0x0B selects fast read.
- R3: The 24-bit start address follows the opcode, most significant bit first. Only the low ADDR_W bits are used and the higher bits are ignored.
- R4: The output enable stays low while opcode, address and dummy bits are being shifted in.
- R5: Data bits change only on falling serial clock edges, most significant bit first. In a plain read, bit 7 of the first byte is driven on the falling edge right after the rising edge that took the last address bit.
- R6: A fast read takes exactly 8 dummy bits after the address. Bit 7 of its first byte is driven on the falling edge after the 8th dummy rising edge.
- R7: The read address increases by one after each byte sent.
- R8: After address 2^ADDR_W-1 is sent, the next byte comes from address 0 with no gap in the bit stream.
- R9: Raising chip select at any point, including mid-byte, ends the transfer. The next low period starts with a fresh opcode.
- R10: Any opcode other than 0x03 and 0x0B keeps the output enable low until chip select rises.
- R11: If busy is high when the 8th opcode bit is taken, the read is ignored and the output enable stays low until chip select rises, even if busy falls later.
- R12: The array model holds the byte (29*a + 7*(a>>8) + 0x3C) mod 256 at address a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from controller |
| busy_i | input | 1 | Program/erase cycle in progress |
| spi_miso | output | 1 | Serial data to controller |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; low means high impedance |

## Verification
The bench builds the block with ADDR_W=10, a 1 KiB array. The wrap from 0x3FF to 0x000 is therefore reached with a short directed read, and random start addresses often land near the top. Address bytes with nonzero upper bits check that the high bits are dropped. The serial clock runs at a half period of 8 system clocks. This exercises the two-stage pin synchroniser and the array read-ahead at a realistic ratio.

// File: rtl/spi_rd_pkg.sv
// Shared types and constants for the SPI read engine.
package spi_rd_pkg;

    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_FAST = 8'h0B;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } rd_state_e;

    // Fill value of the array model at address a.
    function automatic logic [7:0] fill_byte(input int unsigned a);
        return 8'((a * 29) + ((a >> 8) * 7) + 32'h3C);
    endfunction

endpackage

// File: rtl/spi_rd_sync.sv
// Two-flop synchroniser for a bundle of slow asynchronous pins.
// Assumes each pin is stable for several clk cycles between changes.
module spi_rd_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two register stages per bit, each loaded with its reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/spi_rd_array.sv
// Byte-wide synchronous read array model with a fixed fill pattern.
// Assumes one read per clock. The data appears one cycle after the address.
module spi_rd_array import spi_rd_pkg::*; #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Preload the model contents.
    initial begin
        for (int unsigned i = 0; i < DEPTH; i++) mem[i] = fill_byte(i);
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/spi_rd_ctrl.sv
// Command/address shifter, read sequencer and output shifter.
// Assumes synchronised pins, SPI mode 0, and a serial clock half period of
// at least 4 clk cycles so the array read-ahead finishes before each byte.
module spi_rd_ctrl import spi_rd_pkg::*; #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              busy_s,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] addr_o,
    output rd_state_e         st_o,
    output logic              miso_o,
    output logic              oe_o
);
    logic        sck_d;
    logic        rise, fall;
    logic [23:0] sh_q;
    logic [23:0] sh_nx;
    logic [4:0]  cnt_q;
    logic        fast_q;
    logic [7:0]  out_q;
    logic [2:0]  obit_q;

    // Edge detection and next shift value.
    always_comb begin
        rise  = sck_s & ~sck_d;
        fall  = ~sck_s & sck_d;
        sh_nx = {sh_q[22:0], mosi_s};
    end

    // Sequencer: opcode, address, dummy, then data streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            st_o   <= ST_CMD;
            sh_q   <= '0;
            cnt_q  <= '0;
            fast_q <= 1'b0;
            addr_o <= '0;
            out_q  <= '0;
            obit_q <= '0;
            miso_o <= 1'b0;
            oe_o   <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (cs_s) begin
                st_o   <= ST_CMD;
                cnt_q  <= '0;
                obit_q <= '0;
                oe_o   <= 1'b0;
            end else begin
                unique case (st_o)
                    ST_CMD: if (rise) begin
                        sh_q  <= sh_nx;
                        cnt_q <= cnt_q + 5'd1;
                        if (cnt_q == 5'd7) begin
                            cnt_q <= '0;
                            if (!busy_s && sh_nx[7:0] == OP_READ) begin
                                st_o   <= ST_ADDR;
                                fast_q <= 1'b0;
                            end else if (!busy_s && sh_nx[7:0] == OP_FAST) begin
                                st_o   <= ST_ADDR;
                                fast_q <= 1'b1;
                            end else begin
                                st_o <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR: if (rise) begin
                        sh_q  <= sh_nx;
                        cnt_q <= cnt_q + 5'd1;
                        if (cnt_q == 5'd23) begin
                            cnt_q  <= '0;
                            addr_o <= ADDR_W'(sh_nx);
                            st_o   <= fast_q ? ST_DUMMY : ST_DATA;
                        end
                    end
                    ST_DUMMY: if (rise) begin
                        cnt_q <= cnt_q + 5'd1;
                        if (cnt_q == 5'd7) begin
                            cnt_q <= '0;
                            st_o  <= ST_DATA;
                        end
                    end
                    ST_DATA: if (fall) begin
                        oe_o   <= 1'b1;
                        obit_q <= obit_q + 3'd1;
                        if (obit_q == 3'd0) begin
                            miso_o <= rd_data[7];
                            out_q  <= {rd_data[6:0], 1'b0};
                            addr_o <= addr_o + 1'b1;
                        end else begin
                            miso_o <= out_q[7];
                            out_q  <= {out_q[6:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_read_engine.sv
// Top of the SPI read engine: pin synchroniser, sequencer and array model.
// Assumes clk is at least 8 times the serial clock rate.
module spi_read_engine import spi_rd_pkg::*; #(
    parameter int ADDR_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic busy_i,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic [3:0]        pins_s;
    logic              cs_s, sck_s, mosi_s, busy_s;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] rd_addr;
    rd_state_e         state;

    spi_rd_sync #(.W(4), .RST_VAL(4'b0001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({busy_i, spi_mosi, spi_sck, spi_cs_n}),
        .q_o   (pins_s)
    );

    // Split the synchronised bundle.
    always_comb begin
        {busy_s, mosi_s, sck_s, cs_s} = pins_s;
    end

    spi_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .sck_s   (sck_s),
        .mosi_s  (mosi_s),
        .busy_s  (busy_s),
        .rd_data (rd_data),
        .addr_o  (rd_addr),
        .st_o    (state),
        .miso_o  (spi_miso),
        .oe_o    (spi_miso_oe)
    );

    spi_rd_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/spi_read_engine_chk.sv
// Protocol checker for spi_read_engine, attached with bind.
module spi_read_engine_chk import spi_rd_pkg::*; #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              sck_s,
    input rd_state_e         state,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              spi_miso,
    input logic              spi_miso_oe
);
    p_idle_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_miso_oe);

    p_header_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD || state == ST_ADDR || state == ST_DUMMY) |-> !spi_miso_oe);

    p_reject_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !spi_miso_oe);

    p_enable_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> ($past(!sck_s) && $past(sck_s, 2)));

    p_data_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && !$stable(spi_miso))
            |-> ($past(!sck_s) && $past(sck_s, 2)));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state == ST_DATA) && !$stable(rd_addr))
            |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));
endmodule

bind spi_read_engine spi_read_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .sck_s       (sck_s),
    .state       (state),
    .rd_addr     (rd_addr),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe)
);

// File: tb/spi_read_engine_tb.sv
module spi_read_engine_tb;
    localparam int AW   = 10;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
    logic miso, miso_oe;
    int   total = 0, bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    spi_read_engine #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .busy_i(busy), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    // R12 fill pattern, written from the requirement.
    function automatic logic [7:0] exp_byte(input int unsigned a);
        return 8'((a * 29) + (a / 256) * 7 + 60);
    endfunction

    function automatic logic exp_bit(input logic [23:0] start, input int d);
        int unsigned a;
        a = (int'(start) + d / 8) % (1 << AW);
        return exp_byte(a)[7 - d % 8];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    // One transfer: opcode, address, filler bits, with a sample before each rise.
    task automatic txn(input logic [7:0] op, input logic [23:0] a, input int ndata,
                       input bit bsy, input int drop_at, input string req);
        bit valid;
        int base, nbits;
        valid = !bsy && (op == 8'h03 || op == 8'h0B);
        base  = (valid && op == 8'h0B) ? 40 : 32;
        nbits = base + ndata;
        busy  = bsy;
        cs_n  = 1'b0;
        wait_h();
        for (int j = 0; j <= nbits; j++) begin
            if (j == drop_at) busy = 1'b0;
            mosi = (j < 8) ? op[7-j] : (j < 32) ? a[23-(j-8)] : 1'($urandom);
            wait_h();
            if (!valid) chk(miso_oe == 1'b0, req, miso_oe, 0);
            else if (j < base) chk(miso_oe == 1'b0, "R4", miso_oe, 0);
            else chk(miso_oe == 1'b1 && miso == exp_bit(a, j - base), req,
                     {miso_oe, miso}, {1'b1, exp_bit(a, j - base)});
            if (j < nbits) begin
                sck = 1'b1;
                wait_h();
                sck = 1'b0;
            end
        end
        wait_h();
        cs_n = 1'b1;
        busy = 1'b0;
        repeat (2) wait_h();
        chk(miso_oe == 1'b0, "R9 R1 after deselect", miso_oe, 0);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(miso_oe == 1'b0, "R1 reset", miso_oe, 0);

        txn(8'h03, 24'h000000, 32, 1'b0, -1, "R2 R5 R7 plain read");
        txn(8'h0B, 24'h000100, 24, 1'b0, -1, "R6 fast read");
        txn(8'h03, 24'h0003FE, 40, 1'b0, -1, "R8 wrap");
        txn(8'h0B, 24'h0003FF, 16, 1'b0, -1, "R8 fast wrap");
        txn(8'h03, 24'hABC155, 16, 1'b0, -1, "R3 high bits dropped");
        txn(8'h9F, 24'h000010, 16, 1'b0, -1, "R10 other opcode");
        txn(8'h03, 24'h000020, 16, 1'b1, -1, "R11 busy");
        txn(8'h0B, 24'h000020, 16, 1'b1, 12, "R11 busy drops later");
        txn(8'h03, 24'h000040, 13, 1'b0, -1, "R9 mid-byte stop");
        txn(8'h03, 24'h000041, 16, 1'b0, -1, "R9 fresh command");

        for (int k = 0; k < 25; k++) begin
            logic [7:0] op;
            op = ($urandom % 2 == 0) ? 8'h03 : 8'h0B;
            txn(op, 24'($urandom), 1 + int'($urandom % 40), 1'b0, -1, "R12 random read");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule